// File: doc/BRIEF.md
# Multi-Queue Transmit Scheduler

This block picks the next transmit descriptor to send. It chooses from up to sixteen circular descriptor queues and sends each pick into one of eight transmit FIFO channels. Each queue is tied to exactly one channel through a field in its status word. A channel may serve several queues. For every queue the block keeps an 8-bit write index, an 8-bit read index, an empty flag and a 10-bit status word. It also keeps one enable bit per channel.

Software writes these values through a small register port. Each write gives a kind code, a queue number and a 32-bit data word. The same values can be read back combinationally. Each cycle the block looks at which channels signal ready. It issues at most one grant, which carries the channel, the queue number and the descriptor index. On the next clock edge it advances that queue's read index. One cycle after the grant it pulses a pointer-advanced event naming the queue. Fetching the descriptors, block-ack bitmap tracking and retries are left to neighbouring logic.

Register kind codes on `cfg_kind` and `rd_kind`:
- 0: write index, in bits 7:0.
- 1: read index, in bits 7:0.
- 2: status word.
- 3: empty flags.
- 4: channel enables, in bits 7:0.

Top module: `txq_sched`

## Requirements
- R1: After reset:
  - every write index and read index is 0;
  - every status word is 0;
  - all empty flags are 1, so a kind 3 read returns 0x0000FFFF;
  - the channel enables are 0;
  - `grant_valid` and `adv_valid` are low.
- R2: A status write (kind 2) updates status bit b, for b from 0 to 9, only when data bit 10+b is 1. The status bits mean:
  - bit 0: queue active;
  - bits 4:1: channel number;
  - bit 5: window-left;
  - bit 8: mode, where 1 is scheduler-ack and 0 is in-order FIFO.
- R3: An empty-flags write (kind 3) sets queue q's empty flag to data bit q, and only when data bit 16+q is 1. Queues whose mask bit is 0 keep their flag.
- R4: A write-index write (kind 0) sets the queue's empty flag to 1 when the new value equals its read index, and to 0 otherwise. A read-index write (kind 1) applies the same rule against the write index.
- R5: A queue is granted only when three conditions hold: its channel's enable bit is 1, that channel's `ch_ready` bit is 1, and the queue is active and not empty.
- R6: A grant reports the queue's current read index. On the next edge that read index advances by one, modulo 256. When the read index reaches the write index, the empty flag is set and grants for that queue stop. Descriptors are therefore served strictly in order.
- R7: In the cycle after each grant, `adv_valid` is high and `adv_queue` names the granted queue. In a cycle after no grant, `adv_valid` is low.
- R8: When several ready, enabled channels have work in the same cycle, the channel with the highest number is granted.
- R9: Queues that share a channel are served round-robin in ascending queue order, starting after the queue that channel last served. After reset, queue 0 is the first in the order.
- R10: A queue in scheduler-ack mode (status bit 8 = 1) is granted only while its window-left bit (bit 5) is 1. A queue in FIFO mode is granted regardless of bit 5.
- R11: A queue whose channel field holds 8 or more is never granted, and its read index does not move.
- R12: A queue can hold up to 255 pending descriptors. When the write index is one below the read index, exactly 255 grants occur before the queue turns empty. Indices wrap from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_kind | input | 3 | Register kind of the write |
| cfg_queue | input | 4 | Queue addressed by a per-queue write |
| cfg_wdata | input | 32 | Write data |
| rd_kind | input | 3 | Register kind to read |
| rd_queue | input | 4 | Queue to read |
| rd_data | output | 32 | Combinational read data |
| ch_ready | input | 8 | Per-channel ready to accept a descriptor |
| grant_valid | output | 1 | A descriptor is granted this cycle |
| grant_chan | output | 3 | Channel receiving the grant |
| grant_queue | output | 4 | Queue the descriptor comes from |
| grant_index | output | 8 | Descriptor index within that queue |
| adv_valid | output | 1 | Read index advanced, one cycle after a grant |
| adv_queue | output | 4 | Queue whose read index advanced |

## Verification
The bench drains a queue that holds 255 pending descriptors and a queue whose indices wrap past 255. A design that confused full with empty, or compared indices at the wrong width, would stop early, never stop, or report the wrong index. It sends masked writes that change only some status bits or only some empty flags; a design that ignored the masks would disturb fields the write never enabled. It runs competing channels and queues that share a channel. A faulty priority or round-robin would grant the lower channel, or repeat one queue while the others starve. It also covers a scheduler-ack queue with its window closed and a channel field that maps to no channel; a design that skipped either condition would grant there.

// File: rtl/txq_sched.sv
module txq_sched #(
  parameter int NQ  = 16,
  parameter int NCH = 8,
  parameter int IW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_kind,
  input  logic [3:0]    cfg_queue,
  input  logic [31:0]   cfg_wdata,
  input  logic [2:0]    rd_kind,
  input  logic [3:0]    rd_queue,
  output logic [31:0]   rd_data,
  input  logic [7:0]    ch_ready,
  output logic          grant_valid,
  output logic [2:0]    grant_chan,
  output logic [3:0]    grant_queue,
  output logic [7:0]    grant_index,
  output logic          adv_valid,
  output logic [3:0]    adv_queue
);
  localparam int QW = $clog2(NQ);
  localparam int CW = $clog2(NCH);
  localparam logic [2:0] K_WP = 3'd0, K_RP = 3'd1, K_ST = 3'd2, K_EM = 3'd3, K_CE = 3'd4;

  logic [NQ-1:0][IW-1:0] wptr, rptr, wp_n, rp_n;
  logic [NQ-1:0][9:0]    st, st_n;
  logic [NQ-1:0]         empty, em_n, elig;
  logic [NCH-1:0]        chen, req, hit;
  logic [NCH-1:0][NQ-1:0] cand;
  logic [NCH-1:0][QW-1:0] rr;
  logic                  gv;
  logic [CW-1:0]         gch;
  logic [QW-1:0]         gq;

  always_comb begin
    req  = '0;
    cand = '0;
    for (int q = 0; q < NQ; q++) begin
      elig[q] = st[q][0] && !empty[q] && (int'(st[q][4:1]) < NCH) &&
                chen[st[q][CW:1]] && (!st[q][8] || st[q][5]);
      for (int c = 0; c < NCH; c++)
        if (elig[q] && int'(st[q][4:1]) == c) begin
          cand[c][q] = 1'b1;
          req[c]     = 1'b1;
        end
    end
  end

  assign hit = req & ch_ready[NCH-1:0] & chen;
  assign gv  = |hit;

  always_comb begin
    gch = '0;
    for (int c = 0; c < NCH; c++)
      if (hit[c]) gch = CW'(c);
  end

  always_comb begin
    logic [QW-1:0] idx;
    gq = '0;
    for (int k = NQ; k >= 1; k--) begin
      idx = rr[gch] + QW'(k);
      if (cand[gch][idx]) gq = idx;
    end
  end

  assign grant_valid = gv;
  assign grant_chan  = 3'(gch);
  assign grant_queue = 4'(gq);
  assign grant_index = 8'(rptr[gq]);

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      logic wsel, gsel;
      wsel = cfg_we && (cfg_queue == 4'(q));
      gsel = gv && (gq == QW'(q));
      wp_n[q] = (wsel && cfg_kind == K_WP) ? cfg_wdata[IW-1:0] : wptr[q];
      if (wsel && cfg_kind == K_RP)
        rp_n[q] = cfg_wdata[IW-1:0];
      else if (gsel)
        rp_n[q] = rptr[q] + 1'b1;
      else
        rp_n[q] = rptr[q];
      em_n[q] = empty[q];
      if (cfg_we && cfg_kind == K_EM && cfg_wdata[16+q])
        em_n[q] = cfg_wdata[q];
      else if (wsel && (cfg_kind == K_WP || cfg_kind == K_RP))
        em_n[q] = (wp_n[q] == rp_n[q]);
      else if (gsel)
        em_n[q] = (wp_n[q] == rp_n[q]);
      st_n[q] = st[q];
      for (int b = 0; b < 10; b++)
        if (wsel && cfg_kind == K_ST && cfg_wdata[10+b])
          st_n[q][b] = cfg_wdata[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr      <= '0;
      rptr      <= '0;
      st        <= '0;
      empty     <= '1;
      chen      <= '0;
      rr        <= '1;
      adv_valid <= 1'b0;
      adv_queue <= '0;
    end else begin
      wptr      <= wp_n;
      rptr      <= rp_n;
      st        <= st_n;
      empty     <= em_n;
      adv_valid <= gv;
      adv_queue <= 4'(gq);
      if (gv) rr[gch] <= gq;
      if (cfg_we && cfg_kind == K_CE) chen <= cfg_wdata[NCH-1:0];
    end
  end

  always_comb begin
    case (rd_kind)
      K_WP:    rd_data = 32'(wptr[rd_queue]);
      K_RP:    rd_data = 32'(rptr[rd_queue]);
      K_ST:    rd_data = 32'(st[rd_queue]);
      K_EM:    rd_data = 32'(empty);
      K_CE:    rd_data = 32'(chen);
      default: rd_data = '0;
    endcase
  end

  p_grant_allowed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ch_ready[grant_chan] && chen[grant_chan]);

  p_queue_ok_r10: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> st[gq][0] && !empty[gq] && (!st[gq][8] || st[gq][5]) &&
                    st[gq][4:1] == 4'(grant_chan));

  p_top_channel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (((req & ch_ready & chen) >> grant_chan) >> 1) == '0);

  p_rptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !(cfg_we && cfg_kind == K_RP && cfg_queue == grant_queue))
      |=> rptr[$past(gq)] == IW'($past(grant_index) + 8'd1));

  p_adv_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |=> adv_valid && adv_queue == $past(grant_queue));

  p_no_adv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |=> !adv_valid);
endmodule

// File: tb/txq_sched_test.sv
module txq_sched_test;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_kind = 0;
  logic [3:0]  cfg_queue = 0;
  logic [31:0] cfg_wdata = 0;
  logic [2:0]  rd_kind = 0;
  logic [3:0]  rd_queue = 0;
  logic [31:0] rd_data;
  logic [7:0]  ch_ready = 0;
  logic        grant_valid, adv_valid;
  logic [2:0]  grant_chan;
  logic [3:0]  grant_queue, adv_queue;
  logic [7:0]  grant_index;
  int checks = 0, errors = 0;

  txq_sched uut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] k, input int q, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_kind = k; cfg_queue = 4'(q); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(input logic [2:0] k, input int q, output logic [31:0] v);
    rd_kind = k; rd_queue = 4'(q); #1; v = rd_data;
  endtask

  function automatic logic [31:0] stw(input int ch, input bit ack, input bit wsl, input bit act);
    return (32'h3FF << 10) | (32'(ack) << 8) | (32'(wsl) << 5) | (32'(ch) << 1) | 32'(act);
  endfunction

  task automatic step(input logic [7:0] rdy, input bit ev, input int ch, input int q,
                      input int idx, input string tag);
    @(negedge clk);
    ch_ready = rdy; #1;
    chk({tag, " grant_valid"}, grant_valid, ev);
    if (ev) begin
      chk({tag, " chan"}, grant_chan, ch);
      chk({tag, " queue"}, grant_queue, q);
      chk({tag, " index"}, grant_index, idx);
    end
    @(posedge clk); #1;
    ch_ready = 0;
    chk({tag, " adv_valid"}, adv_valid, ev);
    if (ev) chk({tag, " adv_queue"}, adv_queue, q);
  endtask

  task automatic t_reset_r1;
    logic [31:0] v;
    rd(3, 0, v); chk("R1 empty", v, 32'hFFFF);
    rd(0, 5, v); chk("R1 wptr", v, 0);
    rd(1, 5, v); chk("R1 rptr", v, 0);
    rd(2, 5, v); chk("R1 status", v, 0);
    rd(4, 0, v); chk("R1 chen", v, 0);
    chk("R1 grant", grant_valid, 0);
    chk("R1 adv", adv_valid, 0);
  endtask

  task automatic t_status_mask_r2;
    logic [31:0] v;
    cfg(2, 3, (32'h1 << 10) | 32'h3FF);
    rd(2, 3, v); chk("R2 only bit0", v, 32'h001);
    cfg(2, 3, (32'hF << 11) | (32'd2 << 1));
    rd(2, 3, v); chk("R2 chan field", v, 32'h005);
    cfg(2, 3, 32'hFFC00);
    rd(2, 3, v); chk("R2 cleared", v, 0);
  endtask

  task automatic t_empty_mask_r3;
    logic [31:0] v;
    cfg(3, 0, 32'h0005_0000);
    rd(3, 0, v); chk("R3 masked clear", v, 32'hFFFA);
    cfg(3, 0, 32'hFFFF_FFFF);
    rd(3, 0, v); chk("R3 restore", v, 32'hFFFF);
  endtask

  task automatic t_index_write_r4;
    logic [31:0] v;
    cfg(0, 0, 5);
    rd(3, 0, v); chk("R4 wptr differs", v[0], 0);
    cfg(0, 0, 0);
    rd(3, 0, v); chk("R4 wptr equals", v[0], 1);
    cfg(1, 0, 7);
    rd(3, 0, v); chk("R4 rptr differs", v[0], 0);
    cfg(1, 0, 0);
    rd(3, 0, v); chk("R4 rptr equals", v[0], 1);
  endtask

  task automatic t_inorder_r6_r7;
    logic [31:0] v;
    cfg(4, 0, 32'hFF);
    cfg(2, 0, stw(1, 0, 0, 1));
    cfg(0, 0, 3);
    for (int i = 0; i < 3; i++) step(8'h02, 1, 1, 0, i, "R6 R7 in order");
    step(8'h02, 0, 0, 0, 0, "R6 drained");
    rd(3, 0, v); chk("R6 empty set", v[0], 1);
    rd(1, 0, v); chk("R6 rptr", v, 3);
  endtask

  task automatic t_chan_enable_r5;
    cfg(0, 0, 5);
    cfg(4, 0, 32'hFD);
    step(8'h02, 0, 0, 0, 0, "R5 disabled chan");
    cfg(4, 0, 32'hFF);
    step(8'hFD, 0, 0, 0, 0, "R5 not ready");
    step(8'h02, 1, 1, 0, 3, "R5 enabled");
    cfg(2, 0, 32'h400);
    step(8'hFF, 0, 0, 0, 0, "R5 inactive");
  endtask

  task automatic t_priority_r8;
    cfg(2, 1, stw(3, 0, 0, 1)); cfg(0, 1, 1);
    cfg(2, 2, stw(2, 0, 0, 1)); cfg(0, 2, 1);
    step(8'hFF, 1, 3, 1, 0, "R8 high wins");
    step(8'hFF, 1, 2, 2, 0, "R8 next");
    cfg(2, 1, 32'h400); cfg(2, 2, 32'h400);
  endtask

  task automatic t_round_robin_r9;
    for (int q = 4; q <= 6; q++) begin
      cfg(2, q, stw(0, 0, 0, 1)); cfg(0, q, 2);
    end
    for (int r = 0; r < 2; r++)
      for (int q = 4; q <= 6; q++) step(8'h01, 1, 0, q, r, "R9 rotate");
    step(8'h01, 0, 0, 0, 0, "R9 drained");
  endtask

  task automatic t_ack_mode_r10;
    cfg(0, 7, 1);
    cfg(2, 7, stw(5, 1, 0, 1));
    step(8'h20, 0, 0, 0, 0, "R10 window closed");
    cfg(2, 7, (32'h1 << 15) | (32'h1 << 5));
    step(8'h20, 1, 5, 7, 0, "R10 window open");
    cfg(2, 7, 32'h400);
  endtask

  task automatic t_bad_chan_r11;
    logic [31:0] v;
    cfg(0, 8, 1);
    cfg(2, 8, 32'hFFC00 | (32'd9 << 1) | 32'h1);
    step(8'hFF, 0, 0, 0, 0, "R11 no channel");
    rd(1, 8, v); chk("R11 rptr held", v, 0);
    cfg(2, 8, 32'h400);
  endtask

  task automatic t_capacity_r12;
    logic [31:0] v;
    cfg(2, 9, stw(6, 0, 0, 1));
    cfg(0, 9, 255);
    for (int i = 0; i < 255; i++) step(8'h40, 1, 6, 9, i, "R12 full queue");
    step(8'h40, 0, 0, 0, 0, "R12 after 255");
    rd(3, 0, v); chk("R12 empty", v[9], 1);
    cfg(2, 9, 32'h400);
    cfg(2, 10, stw(6, 0, 0, 1));
    cfg(1, 10, 250);
    cfg(0, 10, 4);
    for (int i = 0; i < 10; i++) step(8'h40, 1, 6, 10, (250 + i) % 256, "R12 wrap");
    step(8'h40, 0, 0, 0, 0, "R12 wrap drained");
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset_r1();
    t_status_mask_r2();
    t_empty_mask_r3();
    t_index_write_r4();
    t_inorder_r6_r7();
    t_chan_enable_r5();
    t_priority_r8();
    t_round_robin_r9();
    t_ack_mode_r10();
    t_bad_chan_r11();
    t_capacity_r12();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule